// File: doc/BRIEF.md
# Shared-Bus I2C Write Master

This block is the sending half of an I2C master that may share its two wires with other masters. On a start command it checks the bus is free and the target address is legal. It then opens a transaction with a START condition and clocks out the address byte with the write direction bit. After that it sends bytes from a simple byte stream until the byte flagged as last has been acknowledged, and it closes with a STOP condition. Both wires are open-drain. The block only ever pulls a line low or lets it go, and it reads back the resolved level of each line.

While it sends a 1, the block watches the line. If another master holds the line low, the block has lost arbitration: it lets go of both lines at once and returns to idle without a STOP, so the winner keeps the bus. The block also watches START and STOP conditions on the bus that other masters make, and it will not begin while a foreign transaction is open. The bit rate comes from a run-time divider that sets the length of a quarter bit.

Top module: `mmbus_byte_tx`

## Requirements
- R1: After reset both line drives are released (`sda_oe_o`, `scl_oe_o` low) and `busy_o`, `done_o`, `nack_o`, `arb_lost_o`, `addr_err_o`, `take_o` and `bcast_o` are low.
- R2: A start command with address 7'b0000000 is sent as a broadcast, and `bcast_o` stays high while that transaction is busy.
- R3: A start command whose address has its top five bits equal to 5'b11110 produces a one-cycle `addr_err_o` pulse; no line is driven and `busy_o` stays low.
- R4: A transaction opens with SDA falling while SCL is high (START). It closes with SDA rising while SCL is high (STOP), after which `done_o` pulses for one cycle.
- R5: The first byte on the wire is the 7-bit address followed by a 0 direction bit, and every data byte is 8 bits from `data_i`, all most significant bit first. SDA changes only while SCL is low inside a byte or acknowledge slot.
- R6: After every byte a ninth SCL pulse is sent with SDA released; a low sampled there lets the transaction continue.
- R7: A high sampled in the ninth slot ends the transaction with a STOP, and `nack_o` pulses in the same cycle as `done_o`.
- R8: Each byte taken from the stream gives a one-cycle `take_o` pulse. Bytes are sent until the byte flagged by `data_last_i` is acknowledged. While `data_valid_i` is low between bytes, SCL is held low and the transaction waits.
- R9: If the block releases SDA to send a 1 but samples 0 while SCL is high, it releases both lines and pulses `arb_lost_o`. `busy_o` falls in that same cycle, and neither a STOP nor `done_o` follows.
- R10: A start command is ignored while the block is busy, or while a START from another master has been seen on the bus with no STOP after it.
- R11: Each SCL high phase and each SCL low phase inside a byte lasts 2*(`div_i`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| go_i | input | 1 | Start command |
| addr_i | input | 7 | Target address |
| data_i | input | 8 | Next byte to send |
| data_valid_i | input | 1 | `data_i` holds a byte |
| data_last_i | input | 1 | The byte on `data_i` ends the transaction |
| take_o | output | 1 | Pulse: byte on `data_i` was taken |
| sda_i | input | 1 | Resolved level of the data line |
| scl_i | input | 1 | Resolved level of the clock line |
| sda_oe_o | output | 1 | Pull the data line low |
| scl_oe_o | output | 1 | Pull the clock line low |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | Pulse: STOP has been sent |
| nack_o | output | 1 | Pulse with `done_o`: ended on a not-acknowledge |
| arb_lost_o | output | 1 | Pulse: arbitration lost, bus given up |
| addr_err_o | output | 1 | Pulse: extended-address pattern rejected |
| bcast_o | output | 1 | Current transaction is a broadcast |

## Verification
The assertions assume that the line inputs show the wired-AND of this block's drives and those of other bus agents. They also assume that nothing other than this block pulls SCL low, because clock stretching is not handled. The bench builds `sda_i` and `scl_i` that way. A slave model pulls SDA only in acknowledge slots, and a rival-master model pulls SDA only while SCL is low or while the bus is idle. As a result, the START and STOP conditions the bus monitor sees are always real ones. `div_i` and `addr_i` change only while the block is idle.

// File: rtl/mmbus_tx_pkg.sv
package mmbus_tx_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_LOAD,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [1:0]         ph;
        logic [BYTE_W-1:0]  sh;
        logic [BIT_CW-1:0]  bc;
        logic               last;
        logic               sda_oe;
        logic               scl_oe;
        logic               done;
        logic               nack;
        logic               arb;
        logic               take;
        logic               aerr;
        logic               bcast;
    } tx_regs_t;

endpackage

// File: rtl/mmbus_tx_tick.sv
module mmbus_tx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = 1'b0;
        cnt_d  = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q >= div_i) begin
            tick_o = 1'b1;
            cnt_d  = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a quarter bit never outlasts div_i+1 cycles while the divider holds still
    p_quarter_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $stable(div_i) && cnt_q == div_i) |=> (!run_i || tick_o || cnt_q == '0));
endmodule

// File: rtl/mmbus_tx_busmon.sv
module mmbus_tx_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic bus_busy_o
);
    logic sda_d, sda_q, scl_d, scl_q, busy_d, busy_q;
    logic saw_start, saw_stop;

    always_comb begin
        saw_start = scl_q && scl_i && sda_q && !sda_i;
        saw_stop  = scl_q && scl_i && !sda_q && sda_i;
        sda_d     = sda_i;
        scl_d     = scl_i;
        busy_d    = busy_q;
        if (saw_start)     busy_d = 1'b1;
        else if (saw_stop) busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q  <= 1'b1;
            scl_q  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            sda_q  <= sda_d;
            scl_q  <= scl_d;
            busy_q <= busy_d;
        end
    end

    assign bus_busy_o = busy_q;

    p_busmon_stop_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !bus_busy_o);
endmodule

// File: rtl/mmbus_tx_addrchk.sv
module mmbus_tx_addrchk
    import mmbus_tx_pkg::*;
#(
    parameter logic [4:0] EXT_TAG = 5'b11110
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              is_bcast_o,
    output logic              is_ext_o
);
    localparam int TAG_LSB = ADDR_W - 5;

    always_comb begin
        is_bcast_o = (addr_i == '0);
        is_ext_o   = (addr_i[ADDR_W-1:TAG_LSB] == EXT_TAG);
    end
endmodule

// File: rtl/mmbus_byte_tx.sv
module mmbus_byte_tx
    import mmbus_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div_i,
    input  logic                 go_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    data_i,
    input  logic                 data_valid_i,
    input  logic                 data_last_i,
    output logic                 take_o,
    input  logic                 sda_i,
    input  logic                 scl_i,
    output logic                 sda_oe_o,
    output logic                 scl_oe_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 nack_o,
    output logic                 arb_lost_o,
    output logic                 addr_err_o,
    output logic                 bcast_o
);
    localparam logic [BIT_CW-1:0] TOP_BIT = BIT_CW'(BYTE_W - 1);

    tx_regs_t r_d, r_q;
    logic     tick, bus_busy, is_bcast, is_ext;

    mmbus_tx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st != ST_IDLE),
        .div_i  (div_i),
        .tick_o (tick)
    );

    mmbus_tx_busmon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .scl_i      (scl_i),
        .bus_busy_o (bus_busy)
    );

    mmbus_tx_addrchk u_chk (
        .addr_i     (addr_i),
        .is_bcast_o (is_bcast),
        .is_ext_o   (is_ext)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.nack = 1'b0;
        r_d.arb  = 1'b0;
        r_d.take = 1'b0;
        r_d.aerr = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sda_oe = 1'b0;
                r_d.scl_oe = 1'b0;
                if (go_i && !bus_busy) begin
                    if (is_ext) begin
                        r_d.aerr = 1'b1;
                    end else begin
                        r_d.st    = ST_START;
                        r_d.ph    = 2'd0;
                        r_d.sh    = {addr_i, 1'b0};
                        r_d.last  = 1'b0;
                        r_d.bcast = is_bcast;
                    end
                end
            end
            ST_START: if (tick) begin
                unique case (r_q.ph)
                    2'd0: r_d.ph = 2'd1;
                    2'd1: begin r_d.sda_oe = 1'b1; r_d.ph = 2'd2; end
                    2'd2: begin
                        r_d.scl_oe = 1'b1;
                        r_d.st     = ST_BIT;
                        r_d.ph     = 2'd0;
                        r_d.bc     = TOP_BIT;
                    end
                    default: r_d.ph = 2'd0;
                endcase
            end
            ST_BIT: if (tick) begin
                unique case (r_q.ph)
                    2'd0: begin r_d.sda_oe = ~r_q.sh[BYTE_W-1]; r_d.ph = 2'd1; end
                    2'd1: begin r_d.scl_oe = 1'b0; r_d.ph = 2'd2; end
                    2'd2: begin
                        if (!r_q.sda_oe && !sda_i) begin
                            r_d.arb    = 1'b1;
                            r_d.st     = ST_IDLE;
                            r_d.ph     = 2'd0;
                            r_d.sda_oe = 1'b0;
                            r_d.scl_oe = 1'b0;
                            r_d.bcast  = 1'b0;
                        end else begin
                            r_d.ph = 2'd3;
                        end
                    end
                    default: begin
                        r_d.scl_oe = 1'b1;
                        r_d.sh     = r_q.sh << 1;
                        r_d.ph     = 2'd0;
                        if (r_q.bc == '0) r_d.st = ST_ACK;
                        else              r_d.bc = r_q.bc - 1'b1;
                    end
                endcase
            end
            ST_ACK: if (tick) begin
                unique case (r_q.ph)
                    2'd0: begin r_d.sda_oe = 1'b0; r_d.ph = 2'd1; end
                    2'd1: begin r_d.scl_oe = 1'b0; r_d.ph = 2'd2; end
                    2'd2: begin r_d.sh[0] = sda_i; r_d.ph = 2'd3; end
                    default: begin
                        r_d.scl_oe = 1'b1;
                        r_d.ph     = 2'd0;
                        if (r_q.sh[0] || r_q.last) r_d.st = ST_STOP;
                        else                       r_d.st = ST_LOAD;
                    end
                endcase
            end
            ST_LOAD: begin
                if (data_valid_i) begin
                    r_d.sh   = data_i;
                    r_d.last = data_last_i;
                    r_d.take = 1'b1;
                    r_d.st   = ST_BIT;
                    r_d.ph   = 2'd0;
                    r_d.bc   = TOP_BIT;
                end
            end
            ST_STOP: if (tick) begin
                unique case (r_q.ph)
                    2'd0: begin r_d.sda_oe = 1'b1; r_d.ph = 2'd1; end
                    2'd1: begin r_d.scl_oe = 1'b0; r_d.ph = 2'd2; end
                    2'd2: begin r_d.sda_oe = 1'b0; r_d.ph = 2'd3; end
                    default: begin
                        r_d.done  = 1'b1;
                        r_d.nack  = r_q.sh[0];
                        r_d.st    = ST_IDLE;
                        r_d.ph    = 2'd0;
                        r_d.bcast = 1'b0;
                    end
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sda_oe_o   = r_q.sda_oe;
    assign scl_oe_o   = r_q.scl_oe;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign nack_o     = r_q.nack;
    assign arb_lost_o = r_q.arb;
    assign take_o     = r_q.take;
    assign addr_err_o = r_q.aerr;
    assign bcast_o    = r_q.bcast;

    // data line moves only under a low clock inside byte and acknowledge slots
    p_sda_moves_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && (r_q.st == ST_BIT || r_q.st == ST_ACK)) |-> scl_oe_o);

    p_start_under_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && r_q.st == ST_START) |-> !scl_oe_o);

    p_stop_under_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe_o) && r_q.st == ST_STOP) |-> !scl_oe_o);

    p_loser_lets_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |-> (!busy_o && !sda_oe_o && !scl_oe_o && !done_o));

    p_nack_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |-> done_o);

    p_ext_not_sent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> (!busy_o && !sda_oe_o && !scl_oe_o));

    p_foreign_bus_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && bus_busy && go_i) |=> !busy_o);

    p_take_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

// File: tb/mmbus_byte_tx_test.sv
`timescale 1ns/100ps
module mmbus_byte_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       go_i = 1'b0;
    logic [6:0] addr_i = 7'd0;
    logic [7:0] data_i;
    logic       data_valid_i, data_last_i;
    logic       take_o, sda_oe_o, scl_oe_o, busy_o, done_o, nack_o, arb_lost_o, addr_err_o, bcast_o;
    logic       sda_w, scl_w;

    // task-owned stimulus
    logic [7:0] fbase = 8'd0;
    int         fn = 0;
    logic       hold = 1'b0;
    int         nack_at = 7;
    logic       arm_mode = 1'b0;
    logic       other_hold = 1'b0;

    // monitor-owned state
    logic       ext_sda_low = 1'b0;
    int         fidx = 0;
    logic       pscl = 1'b1, psda = 1'b1;
    int         bitcnt = 0, nb = 0, hi_run = 0, last_hi = 0;
    logic [7:0] shreg = 8'd0;
    logic [7:0] seen [8];
    logic       first_fall = 1'b0, arb_hold = 1'b0;
    int         starts = 0, stops = 0, dones = 0, nacks = 0, arbs = 0, takes = 0, aerrs = 0, bcs = 0;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign sda_w        = ~(sda_oe_o | ext_sda_low | other_hold);
    assign scl_w        = ~scl_oe_o;
    assign data_i       = fbase + 8'(fidx);
    assign data_valid_i = !hold && (fidx < fn);
    assign data_last_i  = (fidx == fn - 1);

    mmbus_byte_tx uut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .go_i(go_i), .addr_i(addr_i),
        .data_i(data_i), .data_valid_i(data_valid_i), .data_last_i(data_last_i),
        .take_o(take_o), .sda_i(sda_w), .scl_i(scl_w), .sda_oe_o(sda_oe_o),
        .scl_oe_o(scl_oe_o), .busy_o(busy_o), .done_o(done_o), .nack_o(nack_o),
        .arb_lost_o(arb_lost_o), .addr_err_o(addr_err_o), .bcast_o(bcast_o)
    );

    // bus slave, rival master and event counters, sampling away from the edge
    always @(negedge clk) begin
        if (done_o) dones++;
        if (nack_o) nacks++;
        if (arb_lost_o) arbs++;
        if (addr_err_o) aerrs++;
        if (bcast_o && busy_o) bcs++;
        if (take_o) begin takes++; fidx++; end
        if (!arm_mode && arb_hold) begin ext_sda_low = 1'b0; arb_hold = 1'b0; end
        if (pscl && scl_w && psda && !sda_w) begin
            starts++; bitcnt = 0; nb = 0; fidx = 0; first_fall = 1'b1;
        end else if (pscl && scl_w && !psda && sda_w) begin
            stops++;
        end
        if (!pscl && scl_w) begin
            if (bitcnt < 8) begin
                shreg = {shreg[6:0], sda_w};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (nb < 8) seen[nb] = shreg;
                    nb++;
                end
            end else begin
                bitcnt = 9;
            end
        end
        if (scl_w) hi_run++;
        if (pscl && !scl_w) begin
            last_hi = hi_run;
            if (bitcnt == 9) begin
                ext_sda_low = 1'b0; bitcnt = 0;
            end else if (bitcnt == 8) begin
                ext_sda_low = ((nb - 1) != nack_at);
            end else if (bitcnt == 0 && first_fall && arm_mode) begin
                ext_sda_low = 1'b1; arb_hold = 1'b1;
            end
            first_fall = 1'b0;
        end
        if (!scl_w) hi_run = 0;
        pscl = scl_w;
        psda = sda_w;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_go(input logic [6:0] a);
        step(1);
        addr_i = a;
        go_i   = 1'b1;
        step(1);
        go_i   = 1'b0;
    endtask

    task automatic wait_end(input int d0, input int a0);
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if (dones != d0 || arbs != a0) break;
        end
        step(3);
    endtask

    // div(4) addr(7) ndata(2) nack_at(3, 7 = none) base(8)
    localparam logic [23:0] VEC [6] = '{
        {4'd0, 7'h50, 2'd1, 3'd7, 8'hA5},
        {4'd3, 7'h00, 2'd2, 3'd7, 8'h3C},
        {4'd1, 7'h2A, 2'd3, 3'd2, 8'h81},
        {4'd2, 7'h7F, 2'd1, 3'd0, 8'h10},
        {4'd0, 7'h13, 2'd2, 3'd7, 8'hFE},
        {4'd1, 7'h55, 2'd3, 3'd3, 8'h00}
    };

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(!sda_oe_o && !scl_oe_o, "R1", {sda_oe_o, scl_oe_o}, 0);
        chk(!busy_o && !done_o && !nack_o && !arb_lost_o, "R1", busy_o, 0);
        chk(!addr_err_o && !take_o && !bcast_o, "R1", addr_err_o, 0);

        foreach (VEC[i]) begin
            automatic logic [3:0] vd = VEC[i][23:20];
            automatic logic [6:0] va = VEC[i][19:13];
            automatic int         vn = VEC[i][12:11];
            automatic int         vk = VEC[i][10:8];
            automatic logic [7:0] vb = VEC[i][7:0];
            automatic int exp_b = (vk <= vn) ? vk + 1 : vn + 1;
            automatic int s0 = starts, p0 = stops, d0 = dones, k0 = nacks, t0 = takes, b0 = bcs, a0 = arbs;
            div_i = 8'(vd); fbase = vb; fn = vn; nack_at = vk;
            pulse_go(va);
            wait_end(d0, a0);
            chk(starts - s0 == 1, "R4", starts - s0, 1);
            chk(stops - p0 == 1, "R4", stops - p0, 1);
            chk(dones - d0 == 1, "R4", dones - d0, 1);
            chk(nb == exp_b, "R6", nb, exp_b);
            chk(seen[0] == {va, 1'b0}, "R5", seen[0], {va, 1'b0});
            for (int j = 1; j < exp_b; j++)
                chk(seen[j] == vb + 8'(j - 1), "R5", seen[j], vb + 8'(j - 1));
            chk((nacks - k0) == ((vk <= vn) ? 1 : 0), "R7", nacks - k0, (vk <= vn) ? 1 : 0);
            chk(takes - t0 == exp_b - 1, "R8", takes - t0, exp_b - 1);
            chk(((bcs - b0) > 0) == (va == 7'd0), "R2", bcs - b0, va == 7'd0);
            chk(last_hi == 2 * (vd + 1), "R11", last_hi, 2 * (vd + 1));
            chk(!busy_o && !sda_oe_o && !scl_oe_o, "R4", busy_o, 0);
        end

        // R3 extended-address pattern rejected
        begin
            automatic int s0 = starts, e0 = aerrs;
            pulse_go(7'h7A);
            step(20);
            chk(aerrs - e0 == 1, "R3", aerrs - e0, 1);
            chk(starts == s0 && !busy_o && !sda_oe_o, "R3", starts - s0, 0);
        end

        // R8 stall with no data: clock held low
        begin
            automatic int d0 = dones, t0 = takes, a0 = arbs;
            div_i = 8'd1; fbase = 8'h66; fn = 1; nack_at = 7; hold = 1'b1;
            pulse_go(7'h21);
            step(300);
            chk(busy_o && !scl_w, "R8", {busy_o, scl_w}, 2);
            chk(takes == t0, "R8", takes - t0, 0);
            hold = 1'b0;
            wait_end(d0, a0);
            chk(nb == 2 && seen[1] == 8'h66, "R8", seen[1], 8'h66);
        end

        // R9 rival master wins on the first address bit
        begin
            automatic int d0 = dones, a0 = arbs, oe_seen = 0;
            div_i = 8'd2; fn = 1; arm_mode = 1'b1;
            pulse_go(7'h40);
            wait_end(d0, a0);
            chk(arbs - a0 == 1, "R9", arbs - a0, 1);
            chk(dones == d0 && !busy_o, "R9", dones - d0, 0);
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (sda_oe_o || scl_oe_o) oe_seen++;
            end
            chk(oe_seen == 0, "R9", oe_seen, 0);
            arm_mode = 1'b0;
            step(5);
        end

        // R10 foreign transaction open: start ignored, then accepted after its STOP
        begin
            automatic int s0, d0, a0;
            other_hold = 1'b1;
            step(3);
            s0 = starts;
            pulse_go(7'h22);
            step(40);
            chk(!busy_o && !sda_oe_o && !scl_oe_o, "R10", busy_o, 0);
            other_hold = 1'b0;
            step(3);
            d0 = dones; a0 = arbs; s0 = starts;
            div_i = 8'd1; fbase = 8'h5A; fn = 2; nack_at = 7;
            pulse_go(7'h22);
            step(30);
            pulse_go(7'h33);
            wait_end(d0, a0);
            chk(starts - s0 == 1 && dones - d0 == 1, "R10", starts - s0, 1);
            chk(seen[0] == {7'h22, 1'b0} && nb == 3, "R10", seen[0], {7'h22, 1'b0});
        end

        summary();
        $finish;
    end
endmodule